// File: doc/BRIEF.md
# LIN Slave Sync-Field Auto-Baud Unit

This unit sits in the receive path of a LIN slave and sets the bit clock divider from the traffic on the bus. It watches the receive line, which is already synchronous to the system clock, for a break: a long dominant (low) stretch. After the break it waits for the recessive delimiter. It then times the 0x55 sync byte with a system-clock counter, from the start-bit falling edge to the fifth falling edge, which spans eight bit periods. The count divided by eight gives clocks per bit, which equals sixteen times the divider. The result is therefore the divider in fixed point with four fractional bits, adjustable in steps of 1/16.

The measured divider is accepted only if it lies within ±15% of the nominal divider. An accepted value is loaded and announced with a one-cycle strobe. A rejected value, a missing fifth edge or a counter overflow raises a sticky sync error, and the previous divider is kept. With mute requested, a hot-plug guard ignores all bus activity until a dominant run of eleven nominal bit periods is seen. Only then does the unit treat the bus as synchronised and start looking for breaks. Byte reception, identifier handling and checksum belong to other blocks.

Top module: `lin_sync_autobaud`

## Requirements
- R1: After reset, div_out is 0, and div_valid, sync_err and bus_synced are all 0.
- R2: A break is accepted only when rx stays low for at least 11 × nom_div system clocks while bus_synced is 1. A shorter low run starts no measurement and produces no result.
- R3: The measurement runs from the first falling edge of rx after the break delimiter to the fifth falling edge. It spans P clocks and yields div_out = floor((P + 4) / 8). In div_out, bits [3:0] are the 1/16 fraction and the upper bits are the integer divider.
- R4: Let tol = floor(15 × nom_div / 100). A result d is accepted when nom_div − tol ≤ d ≤ nom_div + tol. Otherwise sync_err is set and div_out keeps its earlier value. div_out changes only together with div_valid.
- R5: div_valid is a pulse of exactly one cycle, raised on the clock edge that samples the fifth falling edge. div_out holds the new value in that same cycle.
- R6: If the next falling edge is missing for 16 × nom_div clocks after the delimiter or after the first sync edge, the measurement is abandoned and sync_err is set. A saturated counter is treated the same way.
- R7: sync_err is sticky. It is cleared only when the next break is accepted.
- R8: With mute_req at 1, bus_synced stays 0 and breaks are ignored until rx has been low for 11 × nom_div consecutive clocks. bus_synced then rises and stays at 1 while enable is high.
- R9: With mute_req at 0, bus_synced rises on the first clock edge at which enable is 1.
- R10: When enable is 0, bus_synced is cleared on the next edge and any measurement in progress is abandoned. div_out is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx | input | 1 | Sampled LIN receive line, low is dominant |
| enable | input | 1 | Unit enable |
| mute_req | input | 1 | Request hot-plug guarding before the bus is trusted |
| nom_div | input | DIVW | Nominal divider, 4 fractional bits (clocks per bit) |
| div_out | output | DIVW | Measured divider, 4 fractional bits |
| div_valid | output | 1 | One-cycle strobe for a newly accepted divider |
| sync_err | output | 1 | Sticky sync-measurement error |
| bus_synced | output | 1 | Bus considered synchronised |

## Verification
The bench builds the unit with DIVW = 16 and drives nom_div = 160 (a divider of 10.0). At that setting a break lasts about two thousand clocks, the acceptance window is 136 to 184, and the 2560-clock timeout fits comfortably inside a short run. This makes both window edges, values just outside them, a sync byte whose length is not a multiple of eight, a missing fifth edge and a full hot-plug sequence each cheap enough to run as a separate frame.

// File: rtl/lin_ab_pkg.sv
package lin_ab_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BRK,
    ST_WAIT,
    ST_MEAS
  } meas_st_t;

  // allowed deviation: 15 % of the nominal divider, rounded down
  function automatic logic [31:0] ab_tol(input logic [31:0] nom);
    return (nom * 32'd15) / 32'd100;
  endfunction

  function automatic logic ab_in_window(input logic [31:0] nom,
                                        input logic [31:0] div);
    logic [31:0] tol;
    logic [31:0] lo;
    tol = ab_tol(nom);
    lo  = (nom > tol) ? nom - tol : 32'd0;
    return (div >= lo) && (div <= nom + tol);
  endfunction

  // eight bit periods -> clocks per bit, rounded to nearest
  function automatic logic [31:0] ab_div_from_span(input logic [31:0] span);
    return (span + 32'd4) >> 3;
  endfunction

endpackage

// File: rtl/lin_low_run.sv
module lin_low_run #(
  parameter int CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rx,
  output logic [CW-1:0] run,
  output logic          fall
);
  logic rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 1'b1;
      run  <= '0;
    end else begin
      rx_q <= rx;
      if (!en || rx)
        run <= '0;
      else if (~&run)
        run <= run + 1'b1;
    end
  end

  assign fall = en & rx_q & ~rx;
endmodule

// File: rtl/lin_hotplug_guard.sv
module lin_hotplug_guard #(
  parameter int CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          mute,
  input  logic [CW-1:0] run,
  input  logic [CW-1:0] thr,
  output logic          synced,
  output logic          guard_hit
);
  assign guard_hit = mute & (run >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      synced <= 1'b0;
    else
      synced <= en & (!mute | synced | guard_hit);
  end
endmodule

// File: rtl/lin_sync_meas.sv
module lin_sync_meas
  import lin_ab_pkg::*;
#(
  parameter int DIVW = 16,
  parameter int CW   = DIVW + 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            synced,
  input  logic            rx,
  input  logic            fall,
  input  logic [CW-1:0]   run,
  input  logic [CW-1:0]   thr,
  input  logic [CW-1:0]   tmo,
  input  logic [DIVW-1:0] nom,
  output logic [DIVW-1:0] div_out,
  output logic            div_valid,
  output logic            sync_err,
  output logic            brk_evt,
  output logic            abort_evt
);
  meas_st_t        st;
  logic [CW-1:0]   cnt;
  logic [2:0]      edges;
  logic [CW-1:0]   span;
  logic [DIVW-1:0] div_calc;
  logic            win_ok;
  logic            cnt_hit;
  logic            last_edge;

  assign span      = cnt + 1'b1;
  assign div_calc  = DIVW'(ab_div_from_span(32'(span)));
  assign win_ok    = ab_in_window(32'(nom), 32'(div_calc));
  assign cnt_hit   = (span >= tmo) || (&cnt);
  assign last_edge = fall && (edges == 3'd3);
  assign brk_evt   = en && (st == ST_IDLE) && synced && (run >= thr);
  assign abort_evt = en && !fall && cnt_hit &&
                     ((st == ST_WAIT) || (st == ST_MEAS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      edges     <= '0;
      div_out   <= '0;
      div_valid <= 1'b0;
      sync_err  <= 1'b0;
    end else begin
      div_valid <= 1'b0;
      if (!en) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_IDLE: if (brk_evt) begin
            st       <= ST_BRK;
            sync_err <= 1'b0;
          end
          ST_BRK: if (rx) begin
            st  <= ST_WAIT;
            cnt <= '0;
          end
          ST_WAIT: begin
            if (fall) begin
              st    <= ST_MEAS;
              cnt   <= '0;
              edges <= '0;
            end else if (cnt_hit) begin
              st       <= ST_IDLE;
              sync_err <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_MEAS: begin
            if (last_edge) begin
              st <= ST_IDLE;
              if (win_ok) begin
                div_out   <= div_calc;
                div_valid <= 1'b1;
              end else begin
                sync_err <= 1'b1;
              end
            end else if (cnt_hit) begin
              st       <= ST_IDLE;
              sync_err <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
              if (fall) edges <= edges + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lin_sync_autobaud.sv
module lin_sync_autobaud #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx,
  input  logic            enable,
  input  logic            mute_req,
  input  logic [DIVW-1:0] nom_div,
  output logic [DIVW-1:0] div_out,
  output logic            div_valid,
  output logic            sync_err,
  output logic            bus_synced
);
  localparam int CW = DIVW + 5;

  logic [CW-1:0] thr;
  logic [CW-1:0] tmo;
  logic [CW-1:0] run;
  logic          fall;
  logic          guard_hit;
  logic          brk_evt;
  logic          abort_evt;

  // 11 nominal bits of dominant level; 16 nominal bits of silence
  assign thr = CW'(nom_div) * CW'(11);
  assign tmo = CW'({nom_div, 4'b0000});

  lin_low_run #(.CW(CW)) u_run (
    .clk(clk), .rst_n(rst_n), .en(enable), .rx(rx),
    .run(run), .fall(fall)
  );

  lin_hotplug_guard #(.CW(CW)) u_guard (
    .clk(clk), .rst_n(rst_n), .en(enable), .mute(mute_req),
    .run(run), .thr(thr), .synced(bus_synced), .guard_hit(guard_hit)
  );

  lin_sync_meas #(.DIVW(DIVW), .CW(CW)) u_meas (
    .clk(clk), .rst_n(rst_n), .en(enable), .synced(bus_synced),
    .rx(rx), .fall(fall), .run(run), .thr(thr), .tmo(tmo),
    .nom(nom_div), .div_out(div_out), .div_valid(div_valid),
    .sync_err(sync_err), .brk_evt(brk_evt), .abort_evt(abort_evt)
  );
endmodule

// File: rtl/lin_sync_autobaud_chk.sv
module lin_sync_autobaud_chk
  import lin_ab_pkg::*;
#(
  parameter int DIVW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            mute_req,
  input logic [DIVW-1:0] nom_div,
  input logic [DIVW-1:0] div_out,
  input logic            div_valid,
  input logic            sync_err,
  input logic            bus_synced,
  input logic            brk_evt,
  input logic            abort_evt,
  input logic            guard_hit
);
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid |=> !div_valid);

  assert_div_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid |-> ab_in_window(32'(nom_div), 32'(div_out)));

  assert_div_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_out) |-> div_valid);

  assert_valid_no_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid |-> !sync_err);

  assert_synced_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid |-> bus_synced);

  assert_guard_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mute_req && guard_hit) |=> bus_synced);

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> !sync_err);

  assert_abort_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> sync_err);

  assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !bus_synced);

  assert_unmuted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !mute_req) |=> bus_synced);
endmodule

bind lin_sync_autobaud lin_sync_autobaud_chk #(.DIVW(DIVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mute_req(mute_req),
  .nom_div(nom_div), .div_out(div_out), .div_valid(div_valid),
  .sync_err(sync_err), .bus_synced(bus_synced), .brk_evt(brk_evt),
  .abort_evt(abort_evt), .guard_hit(guard_hit)
);

// File: tb/sim_lin_sync_autobaud.sv
`timescale 1ns/1ps
module sim_lin_sync_autobaud;
  localparam int DIVW = 16;
  localparam int NOM  = 160;

  typedef struct {
    bit    is_err;
    int    val;
    string req;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rx = 1'b1;
  logic            enable = 1'b0;
  logic            mute_req = 1'b0;
  logic [DIVW-1:0] nom_div = DIVW'(NOM);
  logic [DIVW-1:0] div_out;
  logic            div_valid;
  logic            sync_err;
  logic            bus_synced;

  int   n_checks = 0;
  int   n_errors = 0;
  int   last_good = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  lin_sync_autobaud #(.DIVW(DIVW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx(rx), .enable(enable), .mute_req(mute_req),
    .nom_div(nom_div), .div_out(div_out), .div_valid(div_valid),
    .sync_err(sync_err), .bus_synced(bus_synced)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_div(input int span);
    return (span + 4) / 8;
  endfunction

  function automatic bit exp_ok(input int nom, input int d);
    int dev;
    dev = (d > nom) ? d - nom : nom - d;
    return dev * 100 <= nom * 15;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_break(input int nbits);
    rx = 1'b0;
    wait_clk(nbits * NOM);
    rx = 1'b1;
    wait_clk(2 * NOM);
  endtask

  // 0x55 LSB first; bit 3 may be stretched by extra clocks
  task automatic send_sync(input int b, input int extra);
    for (int i = 0; i < 10; i++) begin
      rx = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : ((i % 2) == 1);
      wait_clk(b + ((i == 3) ? extra : 0));
    end
    rx = 1'b1;
    wait_clk(2 * b);
  endtask

  task automatic push_frame(input int b, input int extra, input string req);
    exp_t e;
    int   d;
    d = exp_div(8 * b + extra);
    e.req = req;
    if (exp_ok(NOM, d)) begin
      e.is_err = 1'b0;
      e.val = d;
      last_good = d;
    end else begin
      e.is_err = 1'b1;
      e.val = last_good;
    end
    sb.push_back(e);
  endtask

  task automatic frame(input int b, input int extra, input string req);
    push_frame(b, extra, req);
    send_break(13);
    send_sync(b, extra);
  endtask

  // monitor: compares produced results against the scoreboard
  initial begin
    bit prev_err;
    exp_t e;
    prev_err = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && (div_valid || (sync_err && !prev_err))) begin
        if (sb.size() == 0) begin
          n_checks++;
          n_errors++;
          $display("FAIL R2: unexpected result actual div=%0d err=%0d expected none",
                   div_out, sync_err);
        end else begin
          e = sb.pop_front();
          check({e.req, " kind"}, int'(sync_err && !div_valid), int'(e.is_err));
          check({e.req, " div_out"}, int'(div_out), e.val);
        end
      end
      prev_err = sync_err;
    end
  end

  initial begin
    fork
      begin
        // R1 reset state
        wait_clk(3);
        check("R1 div_out", int'(div_out), 0);
        check("R1 div_valid", int'(div_valid), 0);
        check("R1 sync_err", int'(sync_err), 0);
        check("R1 bus_synced", int'(bus_synced), 0);
        rst_n = 1'b1;
        wait_clk(2);
        enable = 1'b1;
        wait_clk(1);
        check("R9 bus_synced unmuted", int'(bus_synced), 1);
        wait_clk(50);

        frame(160, 0, "R3 R5 nominal");
        frame(184, 0, "R4 upper edge");
        frame(136, 0, "R4 lower edge");
        frame(190, 0, "R4 above window");
        wait_clk(500);
        check("R7 sync_err sticky", int'(sync_err), 1);
        check("R4 div_out kept", int'(div_out), 136);
        // R7: break clears the error before the sync byte
        push_frame(130, 0, "R4 below window");
        send_break(13);
        check("R7 sync_err cleared by break", int'(sync_err), 0);
        send_sync(130, 0);
        frame(150, 5, "R3 fractional span");

        // R2 short break: no measurement
        rx = 1'b0; wait_clk(10 * NOM); rx = 1'b1; wait_clk(2 * NOM);
        send_sync(160, 0);
        wait_clk(200);
        check("R2 short break ignored", int'(div_out), 151);

        // R6 missing edges
        begin
          exp_t e;
          e.is_err = 1'b1; e.val = last_good; e.req = "R6 timeout";
          sb.push_back(e);
        end
        send_break(13);
        rx = 1'b0; wait_clk(NOM); rx = 1'b1;
        wait_clk(16 * NOM + 200);
        check("R6 sync_err after timeout", int'(sync_err), 1);

        // R10 disable
        enable = 1'b0;
        wait_clk(1);
        check("R10 bus_synced cleared", int'(bus_synced), 0);
        check("R10 div_out kept", int'(div_out), 151);

        // R8 hot plug
        mute_req = 1'b1;
        enable = 1'b1;
        wait_clk(20);
        check("R8 muted not synced", int'(bus_synced), 0);
        rx = 1'b0; wait_clk(10 * NOM); rx = 1'b1; wait_clk(2 * NOM);
        send_sync(160, 0);
        wait_clk(100);
        check("R8 still not synced", int'(bus_synced), 0);
        push_frame(170, 0, "R8 first frame after guard");
        send_break(13);
        check("R8 synced after long low", int'(bus_synced), 1);
        send_sync(170, 0);
        wait_clk(200);
        check("R2 no pending results", sb.size(), 0);
      end
      begin
        wait_clk(150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule